// File: doc/BRIEF.md
# Dual-Master Register Port with Local-First Arbitration

This block is the register window of one processing engine. Two masters can reach it. One is an external host bus and the other is the engine's own datapath. Both masters can read and write a bank of word registers. When the two request in the same clock cycle, the engine goes first. The host's request is then discarded without taking effect. A one-bit collision flag records that the host request was lost.

The flag sits in a status word at byte offset 0x180 of the window. After each access, host software reads this word. If bit 0 is 1, the software repeats the same access until it reads bit 0 as 0. The host never stalls; retrying is software's job. Host reads return their data one clock after the request, together with a valid strobe. Engine reads also return one clock later, on a separate data port.

Top module: `csr_arb_port`

## Requirements
- R1: After reset, every register reads 0, the collision flag is 0 and the host read-valid strobe is low.
- R2: With the engine idle, a host write to byte offset 4*k (k < NREG) stores the data in register k. A later host read of that offset returns it. Address bits [1:0] are ignored.
- R3: When host and engine both request in one cycle, the engine access is performed and the host access is not. A lost host write leaves every register unchanged. A lost host read returns data 0.
- R4: A lost host access sets the collision flag. The flag reads as bit 0 of the status word at byte offset 0x180; bits 31:1 of that word read 0.
- R5: A host access that is performed clears the collision flag.
- R6: A host read of the status word is never blocked, even when the engine requests in the same cycle. It leaves the flag unchanged and returns the flag's current value.
- R7: host_rvalid is high exactly one cycle after each host read request, lost or not, and is low in every other cycle.
- R8: An engine read returns the addressed register on eng_rdata one cycle after the request. Engine writes take effect in the cycle they are requested.
- R9: Offsets that map to no register read as 0, and writes to them are ignored. Writes to the status offset do not alter the flag's value except through the R4/R5 rule.
- R10: The collision flag holds its value in every cycle with no host request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, one cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host byte offset within the window |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Host read data strobe |
| eng_req | input | 1 | Engine access request |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_addr | input | ADDR_W | Engine byte offset within the window |
| eng_wdata | input | DATA_W | Engine write data |
| eng_rdata | output | DATA_W | Engine read data, one cycle after request |

## Verification
The bench targets four corner cases.

- Collisions on every register, with the engine writing a neighbouring register. A design that let the host win, or that merged both writes, would corrupt the neighbour or store host data into the register.
- Polling the status word during engine traffic. A design that arbitrated status reads would set the flag while it is being polled. A design that cleared the flag on the poll would lose the retry indication.
- Lost reads. These must still strobe valid but return zero; a design that stayed silent would hang the host.
- Unmapped offsets and misaligned low address bits. A design with a loose decode would alias writes onto real registers.

// File: rtl/csr_arb_port.sv
module csr_arb_port #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int NREG = 16,
  parameter logic [ADDR_W-1:0] STAT_OFF = 10'h180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              eng_req,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] eng_rdata
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W = $clog2(NREG);
  localparam logic [WORD_W:0] NREG_V = NREG[WORD_W:0];
  localparam logic [WORD_W-1:0] STAT_WORD = STAT_OFF[ADDR_W-1:2];

  logic [DATA_W-1:0] regs [NREG];
  logic              flag;

  wire unused_low = ^{host_addr[1:0], eng_addr[1:0]};

  wire [WORD_W-1:0] h_word = host_addr[ADDR_W-1:2];
  wire [WORD_W-1:0] e_word = eng_addr[ADDR_W-1:2];
  wire [IDX_W-1:0]  h_idx  = host_addr[2 +: IDX_W];
  wire [IDX_W-1:0]  e_idx  = eng_addr[2 +: IDX_W];
  wire h_hit  = {1'b0, h_word} < NREG_V;
  wire e_hit  = {1'b0, e_word} < NREG_V;
  wire h_stat = h_word == STAT_WORD;
  wire e_stat = e_word == STAT_WORD;

  wire h_poll = host_req & ~host_we & h_stat;
  wire lost   = host_req & eng_req & ~h_poll;
  wire h_go   = host_req & ~lost;

  logic [DATA_W-1:0] h_rd, e_rd;
  always_comb begin
    if (h_stat)     h_rd = {{(DATA_W-1){1'b0}}, flag};
    else if (h_hit) h_rd = regs[h_idx];
    else            h_rd = '0;
    if (e_stat)     e_rd = {{(DATA_W-1){1'b0}}, flag};
    else if (e_hit) e_rd = regs[e_idx];
    else            e_rd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (eng_req && eng_we && e_hit) regs[e_idx] <= eng_wdata;
      if (h_go && host_we && h_hit)   regs[h_idx] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag        <= 1'b0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      eng_rdata   <= '0;
    end else begin
      if (host_req && !h_poll) flag <= lost;
      host_rvalid <= host_req & ~host_we;
      host_rdata  <= (h_go && !host_we) ? h_rd : '0;
      eng_rdata   <= (eng_req && !eng_we) ? e_rd : '0;
    end
  end

  p_lost_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && eng_req && !(!host_we && h_stat)) |=> flag);

  p_win_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !eng_req && !(!host_we && h_stat)) |=> !flag);

  p_poll_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && h_stat) |=> $stable(flag));

  p_idle_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> $stable(flag));

  p_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid);

  p_no_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> !host_rvalid);

  p_lost_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && !h_stat && eng_req) |=> (host_rdata == '0));
endmodule

// File: tb/sim_csr_arb_port.sv
module sim_csr_arb_port;
  localparam int NR = 8;
  logic clk = 0, rst_n = 0;
  logic h_req = 0, h_we = 0, e_req = 0, e_we = 0;
  logic [9:0] h_addr = '0, e_addr = '0;
  logic [31:0] h_wd = '0, e_wd = '0;
  logic [31:0] h_rd, e_rd;
  logic h_rv;
  int checks = 0, errors = 0;
  logic [31:0] model [NR];
  logic mflag = 0;

  always #4 clk = ~clk;

  csr_arb_port #(.ADDR_W(10), .DATA_W(32), .NREG(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(h_req), .host_we(h_we), .host_addr(h_addr),
    .host_wdata(h_wd), .host_rdata(h_rd), .host_rvalid(h_rv), .eng_req(e_req),
    .eng_we(e_we), .eng_addr(e_addr), .eng_wdata(e_wd), .eng_rdata(e_rd));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic hr, input logic hw, input logic [9:0] ha, input logic [31:0] hd,
                     input logic er, input logic ew, input logic [9:0] ea, input logic [31:0] ed);
    h_req = hr; h_we = hw; h_addr = ha; h_wd = hd;
    e_req = er; e_we = ew; e_addr = ea; e_wd = ed;
    @(negedge clk);
    h_req = 0; e_req = 0;
  endtask

  task automatic hread(input string req, input logic [9:0] a, input logic [31:0] exp);
    cyc(1, 0, a, 0, 0, 0, 0, 0);
    chk({req, " rvalid"}, {31'b0, h_rv}, 1);
    chk(req, h_rd, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NR; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rvalid low", {31'b0, h_rv}, 0);
    for (int k = 0; k < NR; k++) hread("R1 reg reset", 10'(4*k), 0);
    hread("R1 flag reset", 10'h180, 0);

    for (int k = 0; k < NR; k++) begin
      model[k] = 32'hA5000000 ^ (32'h01010101 * k) ^ k;
      cyc(1, 1, 10'(4*k), model[k], 0, 0, 0, 0);
      chk("R7 no rvalid on write", {31'b0, h_rv}, 0);
    end
    for (int k = 0; k < NR; k++) hread("R2 readback", 10'(4*k), model[k]);
    for (int k = 0; k < NR; k++) begin
      model[k] = ~model[k];
      cyc(1, 1, 10'(4*k + 3), model[k], 0, 0, 0, 0);
    end
    for (int k = 0; k < NR; k++) hread("R2 low bits ignored", 10'(4*k + 1), model[k]);

    for (int k = 0; k < NR; k++) begin
      model[k] = 32'h3C000000 + 32'(k * 7);
      cyc(0, 0, 0, 0, 1, 1, 10'(4*k), model[k]);
    end
    for (int k = 0; k < NR; k++) begin
      cyc(0, 0, 0, 0, 1, 0, 10'(4*k), 0);
      chk("R8 engine read", e_rd, model[k]);
      chk("R7 no rvalid idle", {31'b0, h_rv}, 0);
    end

    for (int k = 0; k < NR; k++) begin
      model[(k+1)%NR] = 32'hE0000000 | 32'(k);
      cyc(1, 1, 10'(4*k), 32'hDEAD0000 | 32'(k), 1, 1, 10'(4*((k+1)%NR)), model[(k+1)%NR]);
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      hread("R10 flag held idle", 10'h180, 1);
      cyc(1, 0, 10'h180, 0, 1, 0, 10'(4*k), 0);
      chk("R6 poll during engine", h_rd, 1);
      chk("R6 engine still served", e_rd, model[k]);
      hread("R6 flag unchanged", 10'h180, 1);
      hread("R3 lost write no effect", 10'(4*k), model[k]);
      hread("R5 flag cleared", 10'h180, 0);
    end
    for (int k = 0; k < NR; k++) hread("R3 engine write won", 10'(4*k), model[k]);

    cyc(1, 0, 10'h008, 0, 1, 0, 10'h00C, 0);
    chk("R7 lost read rvalid", {31'b0, h_rv}, 1);
    chk("R3 lost read zero", h_rd, 0);
    chk("R3 engine read served", e_rd, model[3]);
    hread("R4 flag set", 10'h180, 1);
    cyc(1, 1, 10'h180, 32'hFFFFFFFF, 0, 0, 0, 0);
    hread("R9 status write clears per R5", 10'h180, 0);
    cyc(1, 1, 10'h180, 32'h0, 1, 0, 0, 0);
    hread("R9 status write lost sets", 10'h180, 1);

    for (int w = NR; w < 16; w++) begin
      cyc(1, 1, 10'(4*w), 32'h12345678, 0, 0, 0, 0);
      hread("R9 unmapped reads zero", 10'(4*w), 0);
    end
    cyc(1, 1, 10'h100, 32'h77777777, 0, 0, 0, 0);
    hread("R9 unmapped 0x100", 10'h100, 0);
    for (int k = 0; k < NR; k++) hread("R9 no alias", 10'(4*k), model[k]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule